// File: doc/BRIEF.md
# UART FIFO Handshake and Interrupt Level Generator

This block drives the two active-low handshake pins and the interrupt level for one UART channel. A host or a block-transfer engine uses these pins to move data in and out of the channel's 32-byte transmit and receive FIFOs. The block reads status from both FIFOs: occupancy counts, the receive empty flag, and the transmit full and empty flags. It also takes a programmable trigger level for each FIFO, a one-cycle receive timeout pulse, and two control bits. One bit enables the FIFOs. The other selects block-transfer mode.

The block has three modes. With the FIFOs disabled, it reports the state of the single holding register in each direction. In this case the FIFO empty flags stand for the holding registers. With the FIFOs enabled and block mode off, the receive pin shows that at least one byte is waiting. The transmit pin shows that the transmit FIFO is fully drained. In block mode the receive pin is held by a latch. The latch sets when the receive FIFO reaches its trigger level or when a timeout occurs, and clears only when the FIFO is empty. This lets a whole block be unloaded in one burst. Also in block mode, the transmit pin stays active while any free slot remains.

Top module: `uart_fifo_handshake`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `rx_rdy_n`=1, `tx_rdy_n`=1 and `irq`=0.
- R2: With `fifo_en`=0, `rx_rdy_n` equals `rx_empty` and `tx_rdy_n` equals the inverse of `tx_empty`, one clock after the inputs.
- R3: With `fifo_en`=1 and `blk_mode`=0, `rx_rdy_n` is low exactly when the receive FIFO holds at least one byte, one clock later.
- R4: With `fifo_en`=1 and `blk_mode`=0, `tx_rdy_n` is low only when the transmit FIFO is empty, one clock later.
- R5: In block mode (`fifo_en`=1, `blk_mode`=1), `rx_rdy_n` goes low one clock after `rx_count` >= `rx_trig` or after `rx_timeout` is high.
- R6: In block mode, once `rx_rdy_n` is low it stays low, even below the trigger level, until a cycle in which `rx_empty` is high. It goes high one clock after that cycle.
- R7: In block mode, if the set condition and `rx_empty` are both true in the same cycle, the set wins and `rx_rdy_n` is low one clock later.
- R8: In block mode, `tx_rdy_n` is high one clock after `tx_full` is high, and low otherwise.
- R9: The receive part of the interrupt is active when `rx_count` >= `rx_trig` with `fifo_en`=1, and when `rx_empty`=0 with `fifo_en`=0.
- R10: The transmit part of the interrupt is active when `tx_empty`=1 or `tx_count` < `tx_trig` with `fifo_en`=1, and when `tx_empty`=1 with `fifo_en`=0. `irq` is the OR of the two parts, registered one clock.
- R11: In any cycle where `fifo_en` or `blk_mode` differs from its value in the previous cycle, the block-mode latch is cleared. A block-mode receive pin therefore reads high one clock after entering block mode, even when the trigger condition already holds. The first cycle after reset counts as a change from `fifo_en`=0, `blk_mode`=0.
- R12: With `fifo_en`=0, `blk_mode` and `rx_timeout` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFO enable control bit |
| blk_mode | input | 1 | Block-transfer mode control bit |
| rx_count | input | CW (6) | Receive FIFO occupancy, 0..DEPTH |
| rx_trig | input | CW (6) | Receive trigger level |
| rx_empty | input | 1 | Receive FIFO (or holding register) empty |
| rx_timeout | input | 1 | Receive timeout pulse |
| tx_count | input | CW (6) | Transmit FIFO occupancy, 0..DEPTH |
| tx_trig | input | CW (6) | Transmit trigger level |
| tx_empty | input | 1 | Transmit FIFO (or holding register) empty |
| tx_full | input | 1 | Transmit FIFO full |
| rx_rdy_n | output | 1 | Receive-ready pin, active low |
| tx_rdy_n | output | 1 | Transmit-ready pin, active low |
| irq | output | 1 | Interrupt level, active high |

## Verification
The bench drives the same occupancy patterns under each of the three modes. Empty, single-byte, mid-range, at-trigger and full counts show that each mode selects its own pin rule: a single byte moves the receive pin in FIFO mode but not in block mode, and a full transmit FIFO is the only thing that raises the transmit pin in block mode. A block-mode sequence falls to below-trigger, then empty, then timeout-only, then timeout-while-empty. This separates the latch hold from its clear and from the set priority. Counts one below and exactly at each trigger level pin down the interrupt comparisons. A mode entry with the trigger already met, together with a reset issued while the latch is set, separates the clear-on-change rule from a plain level decode.

// File: rtl/uart_hs_pkg.sv
// Shared types for the UART handshake block.
// Assumes the two control bits come straight from the FIFO control register.
package uart_hs_pkg;

    // Operating mode as seen by the pin logic
    typedef enum logic [1:0] {
        MODE_CHAR  = 2'd0,
        MODE_FIFO  = 2'd1,
        MODE_BLOCK = 2'd2
    } hs_mode_e;

    // Block mode only counts when the FIFOs are enabled
    function automatic hs_mode_e decode_mode(input logic fifo_on, input logic blk_on);
        if (!fifo_on)     return MODE_CHAR;
        else if (blk_on)  return MODE_BLOCK;
        else              return MODE_FIFO;
    endfunction

endpackage

// File: rtl/uart_hs_rx_ready.sv
// Receive-ready pin generator.
// In character and FIFO modes the pin mirrors the empty flag.
// In block mode a set/clear latch drives the pin. Set wins over clear, and
// a control-bit change or any non-block mode forces the latch clear.
// Assumes rx_count and rx_trig share the same width and are unsigned.
module uart_hs_rx_ready
    import uart_hs_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  hs_mode_e      mode,
    input  logic          mode_chg,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_trig,
    input  logic          rx_empty,
    input  logic          rx_timeout,
    output logic          rx_rdy_n
);

    logic burst_q;
    logic burst_d;
    logic set_cond;
    logic pin_d;

    // Set condition: trigger level reached or timeout seen
    always_comb begin
        set_cond = rx_timeout || (rx_count >= rx_trig);
    end

    // Next latch state with set-over-clear priority
    always_comb begin
        burst_d = burst_q;
        if (mode != MODE_BLOCK || mode_chg) begin
            burst_d = 1'b0;
        end else if (set_cond) begin
            burst_d = 1'b1;
        end else if (rx_empty) begin
            burst_d = 1'b0;
        end
    end

    // Pin value chosen by mode
    always_comb begin
        case (mode)
            MODE_BLOCK: pin_d = ~burst_d;
            default:    pin_d = rx_empty;
        endcase
    end

    // Register latch and pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q  <= 1'b0;
            rx_rdy_n <= 1'b1;
        end else begin
            burst_q  <= burst_d;
            rx_rdy_n <= pin_d;
        end
    end

endmodule

// File: rtl/uart_hs_tx_ready.sv
// Transmit-ready pin generator.
// In character and FIFO modes the pin is low only when everything is drained.
// In block mode the pin is low while any slot is free.
// Assumes tx_full and tx_empty are never both set.
module uart_hs_tx_ready
    import uart_hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hs_mode_e mode,
    input  logic     tx_empty,
    input  logic     tx_full,
    output logic     tx_rdy_n
);

    logic pin_d;

    // Pin value chosen by mode
    always_comb begin
        case (mode)
            MODE_BLOCK: pin_d = tx_full;
            default:    pin_d = ~tx_empty;
        endcase
    end

    // Register the pin
    always_ff @(posedge clk) begin
        if (!rst_n) tx_rdy_n <= 1'b1;
        else        tx_rdy_n <= pin_d;
    end

endmodule

// File: rtl/uart_hs_irq_gen.sv
// Interrupt level generator.
// Combines a receive request and a transmit request into one registered level.
// With FIFOs on, the trigger levels set both requests. With FIFOs off, the
// holding-register flags set them.
module uart_hs_irq_gen #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_on,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_trig,
    input  logic          rx_empty,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] tx_trig,
    input  logic          tx_empty,
    output logic          irq
);

    logic rx_req;
    logic tx_req;

    // Receive request: at or above trigger, or a held byte
    always_comb begin
        if (fifo_on) rx_req = (rx_count >= rx_trig);
        else         rx_req = ~rx_empty;
    end

    // Transmit request: below trigger or drained
    always_comb begin
        if (fifo_on) tx_req = tx_empty || (tx_count < tx_trig);
        else         tx_req = tx_empty;
    end

    // Register the combined level
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= rx_req | tx_req;
    end

endmodule

// File: rtl/uart_fifo_handshake.sv
// Top level: mode decode, control-change detection and the three output
// generators for one UART channel.
// Assumes counts run 0..DEPTH and that the empty flags stand for the holding
// registers when the FIFOs are disabled. All outputs are registered.
module uart_fifo_handshake
    import uart_hs_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          blk_mode,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_trig,
    input  logic          rx_empty,
    input  logic          rx_timeout,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] tx_trig,
    input  logic          tx_empty,
    input  logic          tx_full,
    output logic          rx_rdy_n,
    output logic          tx_rdy_n,
    output logic          irq
);

    hs_mode_e   mode;
    logic [1:0] ctl_q;
    logic       mode_chg;

    // Decode the active mode
    always_comb begin
        mode = decode_mode(fifo_en, blk_mode);
    end

    // Remember last control bits
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= 2'b00;
        else        ctl_q <= {fifo_en, blk_mode};
    end

    // Flag any control-bit change
    always_comb begin
        mode_chg = (ctl_q != {fifo_en, blk_mode});
    end

    uart_hs_rx_ready #(.CW(CW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .mode_chg   (mode_chg),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .rx_empty   (rx_empty),
        .rx_timeout (rx_timeout),
        .rx_rdy_n   (rx_rdy_n)
    );

    uart_hs_tx_ready u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .tx_empty (tx_empty),
        .tx_full  (tx_full),
        .tx_rdy_n (tx_rdy_n)
    );

    uart_hs_irq_gen #(.CW(CW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_on  (fifo_en),
        .rx_count (rx_count),
        .rx_trig  (rx_trig),
        .rx_empty (rx_empty),
        .tx_count (tx_count),
        .tx_trig  (tx_trig),
        .tx_empty (tx_empty),
        .irq      (irq)
    );

endmodule

// File: rtl/uart_fifo_handshake_chk.sv
// Property checker for uart_fifo_handshake, attached with bind.
// Assumes it sees the top-level ports only.
module uart_fifo_handshake_chk #(
    parameter  int DEPTH = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          blk_mode,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] rx_trig,
    input logic          rx_empty,
    input logic          rx_timeout,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] tx_trig,
    input logic          tx_empty,
    input logic          tx_full,
    input logic          rx_rdy_n,
    input logic          tx_rdy_n,
    input logic          irq
);

    logic settled;

    // Marks cycles whose previous edge was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) settled <= 1'b0;
        else        settled <= 1'b1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (rx_rdy_n && tx_rdy_n && !irq));

    // R2
    char_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_empty) |=> rx_rdy_n);

    // R2
    char_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !tx_empty) |=> tx_rdy_n);

    // R4
    fifo_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !blk_mode && !tx_empty) |=> tx_rdy_n);

    // R6
    block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && fifo_en && blk_mode && $stable(fifo_en) && $stable(blk_mode)
         && !rx_rdy_n && !rx_empty) |=> !rx_rdy_n);

    // R7
    block_setwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && fifo_en && blk_mode && $stable(fifo_en) && $stable(blk_mode)
         && rx_timeout) |=> !rx_rdy_n);

    // R8
    block_txfull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && blk_mode && tx_full) |=> tx_rdy_n);

    // R9
    rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && (rx_count >= rx_trig)) |=> irq);

    // R10
    tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |=> irq);

endmodule

bind uart_fifo_handshake uart_fifo_handshake_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_fifo_handshake_test.sv
`timescale 1ns/1ps
module uart_fifo_handshake_test;

    localparam int DEPTH = 32;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NV    = 21;

    // fe, bm, rxc, rxt, to, txc, txt, expected {rx_rdy_n, tx_rdy_n, irq}
    localparam logic [29:0] VEC [NV] = '{
        {1'b0,1'b0,6'd0, 6'd8,1'b0,6'd0, 6'd4,3'b101},
        {1'b0,1'b0,6'd1, 6'd8,1'b0,6'd1, 6'd4,3'b011},
        {1'b0,1'b0,6'd0, 6'd8,1'b0,6'd1, 6'd4,3'b110},
        {1'b0,1'b1,6'd0, 6'd8,1'b1,6'd1, 6'd4,3'b110},
        {1'b1,1'b0,6'd0, 6'd8,1'b0,6'd0, 6'd4,3'b101},
        {1'b1,1'b0,6'd3, 6'd8,1'b0,6'd2, 6'd4,3'b011},
        {1'b1,1'b0,6'd3, 6'd8,1'b0,6'd10,6'd4,3'b010},
        {1'b1,1'b0,6'd8, 6'd8,1'b0,6'd10,6'd4,3'b011},
        {1'b1,1'b0,6'd32,6'd8,1'b0,6'd32,6'd4,3'b011},
        {1'b1,1'b1,6'd10,6'd8,1'b0,6'd5, 6'd4,3'b101},
        {1'b1,1'b1,6'd10,6'd8,1'b0,6'd5, 6'd4,3'b001},
        {1'b1,1'b1,6'd3, 6'd8,1'b0,6'd32,6'd4,3'b010},
        {1'b1,1'b1,6'd0, 6'd8,1'b0,6'd31,6'd4,3'b100},
        {1'b1,1'b1,6'd2, 6'd8,1'b0,6'd31,6'd4,3'b100},
        {1'b1,1'b1,6'd2, 6'd8,1'b1,6'd31,6'd4,3'b000},
        {1'b1,1'b1,6'd0, 6'd8,1'b1,6'd31,6'd4,3'b000},
        {1'b1,1'b1,6'd0, 6'd8,1'b0,6'd31,6'd4,3'b100},
        {1'b1,1'b1,6'd9, 6'd8,1'b0,6'd31,6'd4,3'b001},
        {1'b1,1'b0,6'd5, 6'd8,1'b0,6'd31,6'd4,3'b010},
        {1'b1,1'b1,6'd5, 6'd8,1'b0,6'd31,6'd4,3'b100},
        {1'b1,1'b1,6'd5, 6'd8,1'b0,6'd31,6'd4,3'b100}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fe, bm, to;
    logic [CW-1:0] rxc, rxt, txc, txt;
    logic          rx_rdy_n, tx_rdy_n, irq;
    int            n_chk  = 0;
    int            n_bad  = 0;
    logic          done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_fifo_handshake #(.DEPTH(DEPTH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fe),
        .blk_mode   (bm),
        .rx_count   (rxc),
        .rx_trig    (rxt),
        .rx_empty   (rxc == '0),
        .rx_timeout (to),
        .tx_count   (txc),
        .tx_trig    (txt),
        .tx_empty   (txc == '0),
        .tx_full    (txc == CW'(DEPTH)),
        .rx_rdy_n   (rx_rdy_n),
        .tx_rdy_n   (tx_rdy_n),
        .irq        (irq)
    );

    function automatic string vec_req(int i);
        if (i <= 2)       return "R2 R9 R10";
        else if (i == 3)  return "R12";
        else if (i <= 8)  return "R3 R4 R9 R10";
        else if (i == 9)  return "R11 R8";
        else if (i == 10) return "R5";
        else if (i <= 12) return "R6 R8";
        else if (i <= 14) return "R5";
        else if (i == 15) return "R7";
        else if (i == 16) return "R6";
        else if (i == 17) return "R5 R9";
        else if (i == 18) return "R3 R4";
        else              return "R11";
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if ({rx_rdy_n, tx_rdy_n, irq} !== exp) begin
            n_bad++;
            $display("FAIL %s: {rx_rdy_n,tx_rdy_n,irq} actual %b expected %b",
                     req, {rx_rdy_n, tx_rdy_n, irq}, exp);
        end
    endtask

    task automatic drive(input logic f, input logic b, input int rc, input int rt,
                         input logic t, input int tc, input int tt);
        fe = f; bm = b; rxc = CW'(rc); rxt = CW'(rt);
        to = t; txc = CW'(tc); txt = CW'(tt);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 0, 8, 1'b0, 0, 4);
        @(negedge clk);
        @(negedge clk);
        check("R1 power-up", 3'b110);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][29], VEC[i][28], int'(VEC[i][27:22]), int'(VEC[i][21:16]),
                  VEC[i][15], int'(VEC[i][14:9]), int'(VEC[i][8:3]));
            @(negedge clk);
            check($sformatf("%s vec %0d", vec_req(i), i), VEC[i][2:0]);
        end

        // R9 receive trigger boundary
        drive(1'b1, 1'b0, 7, 8, 1'b0, 10, 4);
        @(negedge clk);
        check("R9 rx one below trigger", 3'b010);
        drive(1'b1, 1'b0, 8, 8, 1'b0, 10, 4);
        @(negedge clk);
        check("R9 rx at trigger", 3'b011);

        // R10 transmit trigger boundary
        drive(1'b1, 1'b0, 0, 8, 1'b0, 3, 4);
        @(negedge clk);
        check("R10 tx one below trigger", 3'b111);
        drive(1'b1, 1'b0, 0, 8, 1'b0, 4, 4);
        @(negedge clk);
        check("R10 tx at trigger", 3'b110);

        // R1 reset while block latch would set
        drive(1'b1, 1'b1, 10, 8, 1'b0, 0, 4);
        @(negedge clk);
        @(negedge clk);
        check("R5 latch set before reset", 3'b001);
        rst_n = 1'b0;
        to    = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 3'b110);
        rst_n = 1'b1;
        to    = 1'b0;
        @(negedge clk);
        check("R11 first cycle after reset", 3'b101);
        @(negedge clk);
        check("R5 set after reset settle", 3'b001);

        finish_run();
    end

endmodule